// File: doc/BRIEF.md
# External Memory Bus Strobe Generator

This block produces the timing strobes for a multiplexed external memory bus from the oscillator clock. A machine cycle lasts twelve oscillator clocks and is split into two equal slots of six clocks. Each slot can carry one address-latch pulse (active high) followed by one program-store read pulse (active low). The block also tells the pad logic two things: which source drives the upper address byte, and whether the shared low byte currently carries an address, carries data, or floats.

For each machine cycle the core presents an access kind: code fetch, data access with a 16-bit pointer, data access with an 8-bit address, or table read from code space. It also presents a latch-strobe gate bit and an external-execution flag. All three are captured at the clock edge that opens the machine cycle and stay fixed until the next one. Data cycles drop the second latch pulse and both read pulses. The gate bit silences the latch strobe during plain fetch cycles unless external execution is active. Table reads always pulse both strobes twice.

Top module: `bus_strobe_gen`

## Requirements
- R1: While reset (rst_ni low) is applied, ale_o is 0, psen_n_o is 1, p0_sel_o is 2'b00 (float) and hi_sel_o is 2'b00 (code source), and this takes effect at once without waiting for a clock edge.
- R2: A machine cycle is 12 clocks. The first rising edge after reset is released opens a cycle, and acc_i, ale_gate_i and ext_exec_i are sampled only at the edge that opens a cycle. Changes to them in the middle of a cycle have no effect on that cycle's outputs.
- R3: A fetch cycle (acc_i 2'b00) with the gate clear drives ale_o high at clocks 0-1 and 6-7 of the cycle, which is two pulses.
- R4: A fetch cycle with ext_exec_i=1 drives psen_n_o low at clocks 3-4 and 9-10, which is two pulses. With ext_exec_i=0 a fetch cycle gives no read pulse.
- R5: A data cycle (acc_i 2'b01 or 2'b10) gives a single ale_o pulse at clocks 0-1 and keeps psen_n_o high for the whole cycle.
- R6: With ale_gate_i=1 and ext_exec_i=0, a fetch cycle gives no ale_o pulse. Data and table cycles still pulse as in R5 and R8.
- R7: With ext_exec_i=1, ale_gate_i has no effect: fetch cycles pulse ale_o twice.
- R8: A table-read cycle (acc_i 2'b11) gives two ale_o pulses and two psen_n_o pulses, whatever the gate and execution flags are.
- R9: hi_sel_o is 2'b00 for fetch and table cycles, 2'b01 (pointer high byte) for 16-bit data cycles and 2'b10 (port-2 latch) for 8-bit data cycles, and it holds for the whole cycle.
- R10: p0_sel_o is 2'b01 (address) whenever ale_o is high. It is 2'b10 (data) for the rest of any slot that has a read pulse, for the rest of the first slot of a data cycle, and for all of the second slot of a data cycle. Otherwise it is 2'b00 (float).
- R11: psen_n_o is never low while ale_o is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 2 | Access kind for the next machine cycle |
| ale_gate_i | input | 1 | Suppress the latch strobe during fetch cycles |
| ext_exec_i | input | 1 | Code is executing from external program memory |
| ale_o | output | 1 | Address-latch strobe, active high |
| psen_n_o | output | 1 | Program-store read strobe, active low |
| hi_sel_o | output | 2 | Upper address byte source select |
| p0_sel_o | output | 2 | Low byte bus phase: float, address or data |

## Verification
Every output is registered from the next-state decode. The values for cycle clock k therefore appear right after the k-th rising edge counted from the edge that opens the cycle, and the inputs given before that opening edge take effect at once. The bench samples one time unit after each of the twelve rising edges of a cycle. It compares each sample with the pattern it predicts for that clock position, and it counts pulses by their leading edges. It drives the next cycle's inputs only after the twelfth sample. It scrambles the inputs after the sixth sample to show that they are ignored mid-cycle.

// File: rtl/bus_strobe_pkg.sv
package bus_strobe_pkg;

   typedef enum logic [1:0] {
      ACC_FETCH  = 2'b00,
      ACC_DATA16 = 2'b01,
      ACC_DATA8  = 2'b10,
      ACC_TABLE  = 2'b11
   } acc_e;

   typedef enum logic [1:0] {
      P0_FLOAT = 2'b00,
      P0_ADDR  = 2'b01,
      P0_DATA  = 2'b10
   } p0_e;

   typedef enum logic [1:0] {
      HI_CODE  = 2'b00,
      HI_PTR   = 2'b01,
      HI_LATCH = 2'b10
   } hi_e;

   typedef struct packed {
      acc_e acc;
      logic ale_gate;
      logic ext_exec;
   } cyc_cfg_t;

   localparam cyc_cfg_t CFG_RESET = '{acc: ACC_FETCH, ale_gate: 1'b0, ext_exec: 1'b0};

endpackage

// File: rtl/bstr_cycle_timer.sv
module bstr_cycle_timer #(
   parameter int unsigned SLOT_CLKS = 6,
   parameter int unsigned SLOTS     = 2,
   parameter int unsigned POS_W     = 3,
   parameter int unsigned SLOT_W    = 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   output logic [POS_W-1:0]  pos_q_o,
   output logic [POS_W-1:0]  pos_d_o,
   output logic [SLOT_W-1:0] slot_q_o,
   output logic [SLOT_W-1:0] slot_d_o,
   output logic              start_d_o
);

   localparam logic [POS_W-1:0]  POS_LAST  = POS_W'(SLOT_CLKS - 1);
   localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

   logic [POS_W-1:0]  pos_q;
   logic [SLOT_W-1:0] slot_q;
   logic              pos_wrap;

   always_comb begin
      pos_wrap  = (pos_q == POS_LAST);
      pos_d_o   = pos_wrap ? '0 : pos_q + 1'b1;
      if (pos_wrap) begin
         slot_d_o = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
      end else begin
         slot_d_o = slot_q;
      end
      start_d_o = pos_wrap && (slot_q == SLOT_LAST);
   end

   // Reset parks on the last clock so the first edge after release opens a cycle.
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pos_q  <= POS_LAST;
         slot_q <= SLOT_LAST;
      end else begin
         pos_q  <= pos_d_o;
         slot_q <= slot_d_o;
      end
   end

   assign pos_q_o  = pos_q;
   assign slot_q_o = slot_q;

   AST_POS_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) pos_q <= POS_LAST); // R2
   AST_SLOT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni) slot_q <= SLOT_LAST); // R2
   AST_CYCLE_ORIGIN: assert property (@(posedge clk_i) disable iff (!rst_ni) start_d_o |=> (pos_q == '0 && slot_q == '0)); // R2

endmodule

// File: rtl/bstr_cfg_latch.sv
module bstr_cfg_latch
   import bus_strobe_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     start_d_i,
   input  cyc_cfg_t cfg_i,
   output cyc_cfg_t cfg_d_o,
   output cyc_cfg_t cfg_q_o
);

   cyc_cfg_t cfg_q;

   assign cfg_d_o = start_d_i ? cfg_i : cfg_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cfg_q <= CFG_RESET;
      end else begin
         cfg_q <= cfg_d_o;
      end
   end

   assign cfg_q_o = cfg_q;

   AST_CFG_HELD_MIDCYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni) !start_d_i |=> $stable(cfg_q)); // R2

endmodule

// File: rtl/bstr_strobe_decode.sv
module bstr_strobe_decode
   import bus_strobe_pkg::*;
#(
   parameter int unsigned SLOTS    = 2,
   parameter int unsigned POS_W    = 3,
   parameter int unsigned SLOT_W   = 1,
   parameter int unsigned ALE_W    = 2,
   parameter int unsigned PSEN_OFS = 3,
   parameter int unsigned PSEN_W   = 2
) (
   input  logic [POS_W-1:0]  pos_i,
   input  logic [SLOT_W-1:0] slot_i,
   input  cyc_cfg_t          cfg_i,
   output logic              ale_o,
   output logic              psen_n_o,
   output p0_e               p0_sel_o,
   output hi_e               hi_sel_o
);

   logic             is_fetch;
   logic             is_data;
   logic             is_table;
   logic             fetch_ale;
   logic             psen_cyc;
   logic [SLOTS-1:0] ale_en;
   logic [SLOTS-1:0] data_full;
   logic [SLOTS-1:0] data_tail;

   assign is_fetch  = (cfg_i.acc == ACC_FETCH);
   assign is_table  = (cfg_i.acc == ACC_TABLE);
   assign is_data   = (cfg_i.acc == ACC_DATA16) || (cfg_i.acc == ACC_DATA8);
   assign fetch_ale = !cfg_i.ale_gate || cfg_i.ext_exec;
   assign psen_cyc  = is_table || (is_fetch && cfg_i.ext_exec);

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      if (s == 0) begin : g_first
         assign ale_en[s]    = is_fetch ? fetch_ale : 1'b1;
         assign data_full[s] = 1'b0;
      end else begin : g_later
         assign ale_en[s]    = is_fetch ? fetch_ale : !is_data;
         assign data_full[s] = is_data;
      end
      assign data_tail[s] = psen_cyc || is_data;
   end

   logic [31:0] pos_w;
   logic        in_ale;
   logic        in_psen;

   always_comb begin
      pos_w   = 32'(pos_i);
      in_ale  = pos_w < ALE_W;
      in_psen = (pos_w >= PSEN_OFS) && (pos_w < PSEN_OFS + PSEN_W);

      ale_o    = ale_en[slot_i] && in_ale;
      psen_n_o = !(psen_cyc && in_psen);

      if (ale_o) begin
         p0_sel_o = P0_ADDR;
      end else if (data_full[slot_i] || (data_tail[slot_i] && !in_ale)) begin
         p0_sel_o = P0_DATA;
      end else begin
         p0_sel_o = P0_FLOAT;
      end

      unique case (cfg_i.acc)
         ACC_DATA16: hi_sel_o = HI_PTR;
         ACC_DATA8:  hi_sel_o = HI_LATCH;
         default:    hi_sel_o = HI_CODE;
      endcase
   end

endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
   import bus_strobe_pkg::*;
#(
   parameter int unsigned STATE_CLKS      = 2,
   parameter int unsigned STATES_PER_SLOT = 3,
   parameter int unsigned SLOTS           = 2,
   parameter int unsigned ALE_W           = 2,
   parameter int unsigned PSEN_OFS        = 3,
   parameter int unsigned PSEN_W          = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic [1:0] acc_i,
   input  logic       ale_gate_i,
   input  logic       ext_exec_i,
   output logic       ale_o,
   output logic       psen_n_o,
   output logic [1:0] hi_sel_o,
   output logic [1:0] p0_sel_o
);

   localparam int unsigned SLOT_CLKS = STATE_CLKS * STATES_PER_SLOT;
   localparam int unsigned POS_W     = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;
   localparam int unsigned SLOT_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1;

   if (SLOTS < 2) begin : g_bad_slots
      $error("bus_strobe_gen: at least two slots per machine cycle are needed");
   end
   if (ALE_W < 1 || PSEN_W < 1) begin : g_bad_width
      $error("bus_strobe_gen: strobe widths must be at least one clock");
   end
   if (PSEN_OFS < ALE_W) begin : g_bad_overlap
      $error("bus_strobe_gen: read strobe would overlap the latch strobe");
   end
   if (PSEN_OFS + PSEN_W > SLOT_CLKS) begin : g_bad_fit
      $error("bus_strobe_gen: read strobe does not fit inside one slot");
   end

   logic [POS_W-1:0]  pos_q, pos_d;
   logic [SLOT_W-1:0] slot_q, slot_d;
   logic              start_d;
   cyc_cfg_t          cfg_in, cfg_d, cfg_q;

   assign cfg_in = '{acc: acc_e'(acc_i), ale_gate: ale_gate_i, ext_exec: ext_exec_i};

   bstr_cycle_timer #(
      .SLOT_CLKS (SLOT_CLKS),
      .SLOTS     (SLOTS),
      .POS_W     (POS_W),
      .SLOT_W    (SLOT_W)
   ) u_timer (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .pos_q_o   (pos_q),
      .pos_d_o   (pos_d),
      .slot_q_o  (slot_q),
      .slot_d_o  (slot_d),
      .start_d_o (start_d)
   );

   bstr_cfg_latch u_cfg (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .start_d_i (start_d),
      .cfg_i     (cfg_in),
      .cfg_d_o   (cfg_d),
      .cfg_q_o   (cfg_q)
   );

   logic ale_nx, psen_n_nx;
   p0_e  p0_nx;
   hi_e  hi_nx;

   // Decode the state the timer moves into, so the strobes leave a flop.
   bstr_strobe_decode #(
      .SLOTS    (SLOTS),
      .POS_W    (POS_W),
      .SLOT_W   (SLOT_W),
      .ALE_W    (ALE_W),
      .PSEN_OFS (PSEN_OFS),
      .PSEN_W   (PSEN_W)
   ) u_decode (
      .pos_i    (pos_d),
      .slot_i   (slot_d),
      .cfg_i    (cfg_d),
      .ale_o    (ale_nx),
      .psen_n_o (psen_n_nx),
      .p0_sel_o (p0_nx),
      .hi_sel_o (hi_nx)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ale_o    <= 1'b0;
         psen_n_o <= 1'b1;
         p0_sel_o <= P0_FLOAT;
         hi_sel_o <= HI_CODE;
      end else begin
         ale_o    <= ale_nx;
         psen_n_o <= psen_n_nx;
         p0_sel_o <= p0_nx;
         hi_sel_o <= hi_nx;
      end
   end

   logic data_q;
   assign data_q = (cfg_q.acc == ACC_DATA16) || (cfg_q.acc == ACC_DATA8);

   AST_NO_STROBE_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni) !(ale_o && !psen_n_o)); // R11
   AST_ADDR_WHILE_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni) ale_o |-> (p0_sel_o == P0_ADDR)); // R10
   AST_HI_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni) !start_d |=> $stable(hi_sel_o)); // R9
   AST_DATA_NO_PSEN: assert property (@(posedge clk_i) disable iff (!rst_ni) data_q |-> psen_n_o); // R5
   AST_DATA_SKIP_ALE: assert property (@(posedge clk_i) disable iff (!rst_ni) (data_q && slot_q != '0) |-> !ale_o); // R5
   AST_FETCH_ALE_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q.acc == ACC_FETCH && cfg_q.ale_gate && !cfg_q.ext_exec) |-> !ale_o); // R6
   AST_TABLE_NO_FLOAT_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cfg_q.acc == ACC_TABLE && !psen_n_o) |-> (p0_sel_o == P0_DATA)); // R8

endmodule

// File: tb/bus_strobe_gen_tb.sv
module bus_strobe_gen_tb;

   localparam int CLK_PERIOD = 10;
   localparam int CYC        = 12;
   localparam int SLOT       = 6;
   localparam int NVEC       = 12;

   // Fields: acc[9:8] gate[7] ext[6] ale pulses[5:4] psen pulses[3:2] hi[1:0]
   localparam logic [9:0] VEC [NVEC] = '{
      {2'b00, 1'b0, 1'b1, 2'd2, 2'd2, 2'b00},   // R3 R4 external fetch
      {2'b00, 1'b0, 1'b0, 2'd2, 2'd0, 2'b00},   // R3 R4 internal fetch
      {2'b00, 1'b1, 1'b0, 2'd0, 2'd0, 2'b00},   // R6 gated fetch
      {2'b00, 1'b1, 1'b1, 2'd2, 2'd2, 2'b00},   // R7 override
      {2'b01, 1'b0, 1'b1, 2'd1, 2'd0, 2'b01},   // R5 R9 16-bit data
      {2'b10, 1'b0, 1'b1, 2'd1, 2'd0, 2'b10},   // R5 R9 8-bit data
      {2'b01, 1'b1, 1'b0, 2'd1, 2'd0, 2'b01},   // R6 data exempt
      {2'b10, 1'b1, 1'b0, 2'd1, 2'd0, 2'b10},   // R6 data exempt
      {2'b11, 1'b0, 1'b0, 2'd2, 2'd2, 2'b00},   // R8 table
      {2'b11, 1'b1, 1'b0, 2'd2, 2'd2, 2'b00},   // R8 table gated
      {2'b11, 1'b1, 1'b1, 2'd2, 2'd2, 2'b00},   // R8 table override
      {2'b00, 1'b0, 1'b1, 2'd2, 2'd2, 2'b00}    // R3 after table
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] acc = 2'b00;
   logic       gate = 1'b0;
   logic       ext = 1'b0;
   logic       ale, psen_n;
   logic [1:0] hi_sel, p0_sel;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_strobe_gen u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .acc_i      (acc),
      .ale_gate_i (gate),
      .ext_exec_i (ext),
      .ale_o      (ale),
      .psen_n_o   (psen_n),
      .hi_sel_o   (hi_sel),
      .p0_sel_o   (p0_sel)
   );

   task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic check_idle(input string req);
      check(ale === 1'b0,     req, "ale idle",  int'(ale),    0);
      check(psen_n === 1'b1,  req, "psen idle", int'(psen_n), 1);
      check(p0_sel === 2'b00, req, "p0 idle",   int'(p0_sel), 0);
      check(hi_sel === 2'b00, req, "hi idle",   int'(hi_sel), 0);
   endtask

   // Inputs are applied now; the next rising edge opens the cycle.
   task automatic run_cycle(input logic [1:0] a, input logic g, input logic e,
                            input int ea, input int ep, input logic [1:0] eh,
                            input bit scramble, input string req);
      int  ale_cnt = 0;
      int  psen_cnt = 0;
      bit  prev_ale = 1'b0;
      bit  prev_psen = 1'b1;
      int  pos_bad = 0;
      int  p0_bad = 0;
      int  hi_bad = 0;
      int  ovl = 0;
      bit  is_data;
      is_data = (a == 2'b01) || (a == 2'b10);
      acc = a; gate = g; ext = e;
      for (int t = 0; t < CYC; t++) begin
         int  s;
         int  p;
         bit  exp_ale;
         bit  exp_ps;
         logic [1:0] exp_p0;
         @(posedge clk);
         #1;
         s = t / SLOT;
         p = t % SLOT;
         exp_ale = ((ea == 2) || (ea == 1 && s == 0)) && (p < 2);
         exp_ps  = (ep == 2) && (p >= 3) && (p < 5);
         if (exp_ale) exp_p0 = 2'b01;
         else if ((is_data && s != 0) || (((ep == 2) || is_data) && p >= 2)) exp_p0 = 2'b10;
         else exp_p0 = 2'b00;
         if (ale && !prev_ale) ale_cnt++;
         if (!psen_n && prev_psen) psen_cnt++;
         prev_ale = ale;
         prev_psen = psen_n;
         if (ale !== exp_ale || psen_n !== !exp_ps) pos_bad++;
         if (p0_sel !== exp_p0) p0_bad++;
         if (hi_sel !== eh) hi_bad++;
         if (ale && !psen_n) ovl++;
         if (scramble && t == 5) begin
            acc = ~a; gate = ~g; ext = ~e;
         end
      end
      check(ale_cnt == ea,  req, "ale pulses per cycle",  ale_cnt,  ea);
      check(psen_cnt == ep, req, "psen pulses per cycle", psen_cnt, ep);
      check(pos_bad == 0,   req, "strobe clock positions wrong", pos_bad, 0);
      check(hi_bad == 0,    {req, " R9"},  "hi select clocks wrong", hi_bad, 0);
      check(p0_bad == 0,    {req, " R10"}, "p0 phase clocks wrong",  p0_bad, 0);
      check(ovl == 0,       "R11", "overlap clocks", ovl, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual running expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check_idle("R1");
      @(negedge clk);
      rst_n = 1'b1;

      // Table walk; inputs scrambled mid-cycle (R2).
      for (int v = 0; v < NVEC; v++) begin
         run_cycle(VEC[v][9:8], VEC[v][7], VEC[v][6],
                   int'(VEC[v][5:4]), int'(VEC[v][3:2]), VEC[v][1:0],
                   1'b1, "R2 vector");
      end

      // R1: asynchronous reset in the middle of a strobe pattern.
      acc = 2'b11; gate = 1'b0; ext = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check_idle("R1 mid-cycle");
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R2: first edge after release opens a fresh cycle.
      run_cycle(2'b00, 1'b0, 1'b1, 2, 2, 2'b00, 1'b0, "R2 restart");
      // R5 back-to-back data cycles, then R7 override once more.
      run_cycle(2'b10, 1'b1, 1'b1, 1, 0, 2'b10, 1'b0, "R5 data");
      run_cycle(2'b01, 1'b0, 1'b0, 1, 0, 2'b01, 1'b0, "R5 data");
      run_cycle(2'b00, 1'b1, 1'b1, 2, 2, 2'b00, 1'b1, "R7 override");
      run_cycle(2'b00, 1'b1, 1'b0, 0, 0, 2'b00, 1'b1, "R6 gated");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule